// File: doc/BRIEF.md
# ARINC 429 Receive Bit and Word Decoder

This block turns the digital outputs of an ARINC 429 line comparator into complete 32-bit words. There are three outputs: a level above the positive threshold, a level below the negative threshold, and a level inside the null band. The block takes one sample of the bus on each 1 MHz timing enable at the high rate. At the low rate it takes one sample on every eighth enable. In both cases each bit period holds ten samples.

Each level has its own ten-sample history. A bit is recognised when the history shows a pulse followed by a return to null. Consecutive bits must arrive a plausible distance apart, and a new word is armed only after a sustained null gap. After the 32nd bit, the word is presented with a one-cycle strobe. Parity can optionally be folded into the top bit. Clearing the enable input makes the block deaf to the bus.

Top module: `a429_rx_decoder`

## Requirements
- R1: With `low_speed`=0 every clock carrying `tick_1mhz`=1 takes one bus sample. With `low_speed`=1 only every eighth such clock does. Level inputs on clocks with `tick_1mhz`=0 have no effect.
- R2: A sample records a level only when exactly one of `lvl_one`, `lvl_zero`, `lvl_null` is high. A sample with two levels high records nothing, so a pulse broken by such a sample is not a bit.
- R3: A bit is accepted when the older five samples of the one (or zero) history hold three consecutive hits and the newer five samples of the null history hold three consecutive hits. The value is 1 for the one history and 0 for the zero history. The first bit accepted goes to `word_out[0]` and the 32nd goes to `word_out[31]`.
- R4: After the first bit of a word, each bit must be accepted 8 to 12 samples after the previous one, both limits included. A bit outside that window discards the partial word. So does a gap of 13 samples with no bit.
- R5: A word that stops after fewer than 32 bits produces no strobe.
- R6: A word is armed only after three gap checks in a row succeed. The checks fall 10 samples apart, and each needs three consecutive null hits in both the older and the newer half of the null history. The gap must be rebuilt after reset, after disable, after a strobe and after a discard.
- R7: Once the 32nd bit is accepted, `word_valid` is high for exactly one clock. `word_out` takes the new word on that clock and holds it until the next strobe.
- R8: With `parity_en`=1, `word_out[31]` is 1 when the 32 received bits hold an even number of ones and 0 when they hold an odd number. With `parity_en`=0 all 32 bits are passed unchanged.
- R9: While `rx_enable`=0, no word is produced and all reception progress is cleared.
- R10: After reset, `word_valid` is 0 and `word_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1mhz | input | 1 | 1 MHz timing enable, one clock wide |
| low_speed | input | 1 | 0: high bit rate, 1: low bit rate |
| rx_enable | input | 1 | 1: receive, 0: ignore the bus |
| parity_en | input | 1 | 1: replace bit 31 with the odd-parity result |
| lvl_one | input | 1 | Comparator: bus in the positive band |
| lvl_zero | input | 1 | Comparator: bus in the negative band |
| lvl_null | input | 1 | Comparator: bus in the null band |
| word_out | output | 32 | Last completed word |
| word_valid | output | 1 | One-clock end-of-sequence strobe |

## Verification
The hardest cases to reach from the ports are the bit-spacing limits. With clean return-to-zero pulses the detection rule can never space bits closer than 8 samples. The stimulus therefore shapes single bits instead: it shortens the trailing null of one bit to reach exactly 8, and stretches it to reach exactly 12 and 13. The gap rule is reached by sending a second word directly after an accepted one, with no idle nulls between them. A sample with two levels high breaks one pulse, which separates exclusive recording from priority recording. Every sample is followed by a non-tick clock that carries a contradicting level, so any leak through the timing enable corrupts the word.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  typedef enum logic {
    ST_GAP = 1'b0,
    ST_RX  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/a429_band_sampler.sv
module a429_band_sampler #(
  parameter int SR_LEN = 10,
  parameter int RUN    = 3,
  parameter int LS_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic low_speed,
  input  logic lvl_one,
  input  logic lvl_zero,
  input  logic lvl_null,
  output logic samp_step,
  output logic bit_evt,
  output logic bit_val,
  output logic bit_bad,
  output logic gap_null
);
  localparam int HALF = SR_LEN / 2;
  localparam int NWIN = HALF - RUN + 1;
  localparam int DIVW = (LS_DIV > 1) ? $clog2(LS_DIV) : 1;

  logic [DIVW-1:0]   pre_q, pre_d;
  logic [SR_LEN-1:0] one_q, one_d, zero_q, zero_d, null_q, null_d;
  logic              step_q, step_d, cond_q, cond_d;
  logic              sample_en, in_one, in_zero, in_null;
  logic [NWIN-1:0]   one_win, zero_win, nhi_win, nlo_win;
  logic              one_hi, zero_hi, null_hi, null_lo, cond;

  assign sample_en = tick & (~low_speed | (pre_q == DIVW'(LS_DIV - 1)));
  assign in_one    = lvl_one  & ~lvl_zero & ~lvl_null;
  assign in_zero   = lvl_zero & ~lvl_one  & ~lvl_null;
  assign in_null   = lvl_null & ~lvl_one  & ~lvl_zero;

  always_comb begin
    pre_d  = pre_q;
    one_d  = one_q;
    zero_d = zero_q;
    null_d = null_q;
    step_d = 1'b0;
    cond_d = cond_q;
    if (clr) begin
      pre_d  = '0;
      one_d  = '0;
      zero_d = '0;
      null_d = '0;
      cond_d = 1'b0;
    end else begin
      if (tick && low_speed)
        pre_d = (pre_q == DIVW'(LS_DIV - 1)) ? '0 : pre_q + DIVW'(1);
      if (sample_en) begin
        one_d  = {one_q[SR_LEN-2:0], in_one};
        zero_d = {zero_q[SR_LEN-2:0], in_zero};
        null_d = {null_q[SR_LEN-2:0], in_null};
      end
      step_d = sample_en;
      if (step_q) cond_d = cond;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      one_q  <= '0;
      zero_q <= '0;
      null_q <= '0;
      step_q <= 1'b0;
      cond_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      one_q  <= one_d;
      zero_q <= zero_d;
      null_q <= null_d;
      step_q <= step_d;
      cond_q <= cond_d;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign one_win[g]  = &one_q[HALF + g +: RUN];
    assign zero_win[g] = &zero_q[HALF + g +: RUN];
    assign nhi_win[g]  = &null_q[HALF + g +: RUN];
    assign nlo_win[g]  = &null_q[g +: RUN];
  end

  assign one_hi  = |one_win;
  assign zero_hi = |zero_win;
  assign null_hi = |nhi_win;
  assign null_lo = |nlo_win;
  assign cond    = (one_hi | zero_hi) & null_lo;

  assign samp_step = step_q;
  assign bit_evt   = step_q & cond & ~cond_q;
  assign bit_val   = one_hi;
  assign bit_bad   = one_hi & zero_hi;
  assign gap_null  = null_hi & null_lo;
endmodule

// File: rtl/a429_word_assembler.sv
module a429_word_assembler
  import a429_rx_pkg::*;
#(
  parameter int WORD_BITS  = 32,
  parameter int SP_MIN     = 8,
  parameter int SP_MAX     = 12,
  parameter int GAP_NEED   = 3,
  parameter int GAP_PERIOD = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 parity_en,
  input  logic                 samp_step,
  input  logic                 bit_evt,
  input  logic                 bit_val,
  input  logic                 bit_bad,
  input  logic                 gap_null,
  output logic [WORD_BITS-1:0] word_out,
  output logic                 word_valid,
  output logic                 rx_armed
);
  localparam int IDXW = $clog2(WORD_BITS);
  localparam int SPW  = $clog2(SP_MAX + 3);
  localparam int GSW  = (GAP_PERIOD > 1) ? $clog2(GAP_PERIOD) : 1;
  localparam int GCW  = $clog2(GAP_NEED + 1);

  rx_state_e            st_q, st_d;
  logic [IDXW-1:0]      idx_q, idx_d;
  logic [SPW-1:0]       spc_q, spc_d, elapsed;
  logic [GSW-1:0]       gsub_q, gsub_d;
  logic [GCW-1:0]       gcnt_q, gcnt_d;
  logic [WORD_BITS-1:0] sh_q, sh_d, word_q, word_d, assembled;
  logic                 eos_q, eos_d;
  logic                 spacing_ok, first_bit, last_bit, restart;

  assign elapsed    = spc_q + SPW'(1);
  assign spacing_ok = (elapsed >= SPW'(SP_MIN)) && (elapsed <= SPW'(SP_MAX));
  assign first_bit  = (idx_q == '0);
  assign last_bit   = (idx_q == IDXW'(WORD_BITS - 1));

  always_comb begin
    assembled = sh_q;
    assembled[idx_q] = bit_val;
  end

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    spc_d   = spc_q;
    gsub_d  = gsub_q;
    gcnt_d  = gcnt_q;
    sh_d    = sh_q;
    word_d  = word_q;
    eos_d   = 1'b0;
    restart = 1'b0;
    if (clr) begin
      restart = 1'b1;
    end else if (samp_step) begin
      case (st_q)
        ST_GAP: begin
          if (gsub_q == GSW'(GAP_PERIOD - 1)) begin
            gsub_d = '0;
            if (!gap_null) begin
              gcnt_d = '0;
            end else if (gcnt_q == GCW'(GAP_NEED - 1)) begin
              st_d   = ST_RX;
              gcnt_d = '0;
              idx_d  = '0;
              spc_d  = '0;
            end else begin
              gcnt_d = gcnt_q + GCW'(1);
            end
          end else begin
            gsub_d = gsub_q + GSW'(1);
          end
        end
        default: begin
          if (bit_evt) begin
            if (bit_bad || (!first_bit && !spacing_ok)) begin
              restart = 1'b1;
            end else begin
              sh_d  = assembled;
              spc_d = '0;
              if (last_bit) begin
                eos_d   = 1'b1;
                word_d  = parity_en ? {~^assembled, assembled[WORD_BITS-2:0]} : assembled;
                restart = 1'b1;
              end else begin
                idx_d = idx_q + IDXW'(1);
              end
            end
          end else if (!first_bit) begin
            if (elapsed > SPW'(SP_MAX)) restart = 1'b1;
            else                        spc_d = elapsed;
          end
        end
      endcase
    end
    if (restart) begin
      st_d   = ST_GAP;
      idx_d  = '0;
      spc_d  = '0;
      gsub_d = '0;
      gcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_GAP;
      idx_q  <= '0;
      spc_q  <= '0;
      gsub_q <= '0;
      gcnt_q <= '0;
      sh_q   <= '0;
      word_q <= '0;
      eos_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      spc_q  <= spc_d;
      gsub_q <= gsub_d;
      gcnt_q <= gcnt_d;
      sh_q   <= sh_d;
      word_q <= word_d;
      eos_q  <= eos_d;
    end
  end

  assign word_out   = word_q;
  assign word_valid = eos_q;
  assign rx_armed   = (st_q == ST_RX);
endmodule

// File: rtl/a429_rx_decoder.sv
module a429_rx_decoder #(
  parameter int WORD_BITS  = 32,
  parameter int SR_LEN     = 10,
  parameter int RUN        = 3,
  parameter int LS_DIV     = 8,
  parameter int SP_MIN     = 8,
  parameter int SP_MAX     = 12,
  parameter int GAP_NEED   = 3,
  parameter int GAP_PERIOD = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_1mhz,
  input  logic                 low_speed,
  input  logic                 rx_enable,
  input  logic                 parity_en,
  input  logic                 lvl_one,
  input  logic                 lvl_zero,
  input  logic                 lvl_null,
  output logic [WORD_BITS-1:0] word_out,
  output logic                 word_valid
);
  logic [1:0] rst_pipe;
  logic       rst_int_n, clr;
  logic       samp_step, bit_evt, bit_val, bit_bad, gap_null, rx_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];
  assign clr       = ~rx_enable;

  a429_band_sampler #(
    .SR_LEN (SR_LEN),
    .RUN    (RUN),
    .LS_DIV (LS_DIV)
  ) u_sampler (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .tick      (tick_1mhz),
    .low_speed (low_speed),
    .lvl_one   (lvl_one),
    .lvl_zero  (lvl_zero),
    .lvl_null  (lvl_null),
    .samp_step (samp_step),
    .bit_evt   (bit_evt),
    .bit_val   (bit_val),
    .bit_bad   (bit_bad),
    .gap_null  (gap_null)
  );

  a429_word_assembler #(
    .WORD_BITS  (WORD_BITS),
    .SP_MIN     (SP_MIN),
    .SP_MAX     (SP_MAX),
    .GAP_NEED   (GAP_NEED),
    .GAP_PERIOD (GAP_PERIOD)
  ) u_assembler (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (clr),
    .parity_en  (parity_en),
    .samp_step  (samp_step),
    .bit_evt    (bit_evt),
    .bit_val    (bit_val),
    .bit_bad    (bit_bad),
    .gap_null   (gap_null),
    .word_out   (word_out),
    .word_valid (word_valid),
    .rx_armed   (rx_armed)
  );
endmodule

// File: rtl/a429_rx_decoder_chk.sv
module a429_rx_decoder_chk #(
  parameter int WORD_BITS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 rx_enable,
  input logic                 samp_step,
  input logic                 rx_armed,
  input logic                 word_valid,
  input logic [WORD_BITS-1:0] word_out
);
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    samp_step |-> $past(tick)); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R7

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_out)); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !word_valid); // R9

  AST_DISABLE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !rx_armed); // R6

  AST_ARM_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_armed) |-> $past(samp_step)); // R6
endmodule

bind a429_rx_decoder a429_rx_decoder_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .tick       (tick_1mhz),
  .rx_enable  (rx_enable),
  .samp_step  (samp_step),
  .rx_armed   (rx_armed),
  .word_valid (word_valid),
  .word_out   (word_out)
);

// File: tb/a429_rx_decoder_tb.sv
module a429_rx_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        low_speed = 1'b0;
  logic        rx_enable = 1'b1;
  logic        parity_en = 1'b0;
  logic        lvl_one = 1'b0;
  logic        lvl_zero = 1'b0;
  logic        lvl_null = 1'b1;
  logic [31:0] word_out;
  logic        word_valid;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  logic [31:0] last_word = '0;

  always #4 clk = ~clk;

  a429_rx_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1mhz(tick), .low_speed(low_speed),
    .rx_enable(rx_enable), .parity_en(parity_en), .lvl_one(lvl_one),
    .lvl_zero(lvl_zero), .lvl_null(lvl_null), .word_out(word_out),
    .word_valid(word_valid)
  );

  always @(negedge clk) begin
    if (word_valid) begin
      strobes   <= strobes + 1;
      last_word <= word_out;
    end
  end

  // vector: data, parity_en, low_speed, rx_enable, kind
  // kind 0 plain, 1 spacing 8, 2 spacing 12, 3 spacing 13, 4 only 31 bits,
  // 5 second word with no gap, 6 double-level sample breaks a pulse
  localparam int NV = 14;
  localparam logic [37:0] VECS [0:NV-1] = '{
    {32'hA5A5_0F0F, 1'b0, 1'b0, 1'b1, 3'd0},
    {32'h1234_5678, 1'b1, 1'b0, 1'b1, 3'd0},
    {32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 3'd0},
    {32'h0000_0001, 1'b1, 1'b0, 1'b1, 3'd0},
    {32'h8000_0000, 1'b1, 1'b0, 1'b1, 3'd0},
    {32'h0F0F_3C3C, 1'b0, 1'b1, 1'b1, 3'd0},
    {32'h5555_AAAA, 1'b0, 1'b0, 1'b1, 3'd1},
    {32'h3333_CCCC, 1'b0, 1'b0, 1'b1, 3'd2},
    {32'h7777_1111, 1'b0, 1'b0, 1'b1, 3'd3},
    {32'h0123_4567, 1'b0, 1'b0, 1'b1, 3'd4},
    {32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 3'd0},
    {32'hC0FF_EE00, 1'b0, 1'b0, 1'b1, 3'd5},
    {32'h2468_ACE1, 1'b0, 1'b0, 1'b1, 3'd6},
    {32'h0BAD_F00D, 1'b1, 1'b0, 1'b1, 3'd0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] d, input logic par);
    // R8: bit 31 becomes 1 for an even count of ones, 0 for odd
    if (par) return {~^d, d[30:0]};
    return d;
  endfunction

  // level codes: 0 none, 1 one, 2 zero, 3 null, 4 one and zero together
  task automatic drive(input int lvl);
    lvl_one  = (lvl == 1) || (lvl == 4);
    lvl_zero = (lvl == 2) || (lvl == 4);
    lvl_null = (lvl == 3);
  endtask

  // one bus sample: tick clock with the level, then a non-tick clock with a contradicting level (R1)
  task automatic put(input int lvl);
    for (int r = 0; r < (low_speed ? 8 : 1); r++) begin
      @(negedge clk); tick = 1'b1; drive(lvl);
      @(negedge clk); tick = 1'b0; drive((lvl == 3) ? 1 : 3);
    end
  endtask

  task automatic send_bit(input logic b, input int h, input int n, input bit broken);
    for (int k = 0; k < h; k++) put((broken && k == 2) ? 4 : (b ? 1 : 2));
    for (int k = 0; k < n; k++) put(3);
  endtask

  task automatic send_word(input logic [31:0] d, input int kind, input int lead);
    for (int k = 0; k < lead; k++) put(3);
    for (int i = 0; i < ((kind == 4) ? 31 : 32); i++) begin
      int n;
      n = 5;
      if (i == 10 && kind == 1) n = 3;
      if (i == 10 && kind == 2) n = 7;
      if (i == 10 && kind == 3) n = 8;
      send_bit(d[i], 5, n, (kind == 6) && (i == 5));
    end
  endtask

  initial begin
    #(200000 * 8);
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(word_valid == 1'b0, "R10 valid in reset", {31'd0, word_valid}, 32'd0);
    check(word_out == 32'd0, "R10 word in reset", word_out, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(word_valid == 1'b0, "R10 valid after reset", {31'd0, word_valid}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] d;
      int          kind, base, exp_n;
      string       req;
      d         = VECS[v][37:6];
      parity_en = VECS[v][5];
      low_speed = VECS[v][4];
      rx_enable = VECS[v][3];
      kind      = int'(VECS[v][2:0]);
      base      = strobes;
      exp_n     = (!rx_enable || kind == 3 || kind == 4 || kind == 6) ? 0 : 1;
      case (kind)
        1, 2, 3: req = "R4 spacing";
        4:       req = "R5 short word";
        5:       req = "R6 no gap";
        6:       req = "R2 double level";
        default: req = !rx_enable ? "R9 disabled" : (low_speed ? "R1 low rate" : "R3 word");
      endcase
      send_word(d, kind, 40);
      if (kind == 5) send_word(~d, 0, 0);
      repeat (20) @(negedge clk);
      check(strobes - base == exp_n, req, 32'(strobes - base), 32'(exp_n));
      if (exp_n == 1)
        check(last_word == expect_word(d, parity_en), parity_en ? "R8 parity" : req,
              last_word, expect_word(d, parity_en));
      rx_enable = 1'b1;
    end

    // R7: one strobe per word, word held afterwards
    check(word_valid == 1'b0, "R7 strobe ended", {31'd0, word_valid}, 32'd0);

    // R10: reset in the middle of a word, then a fresh word needs a new gap
    low_speed = 1'b0;
    parity_en = 1'b0;
    for (int k = 0; k < 40; k++) put(3);
    for (int i = 0; i < 12; i++) send_bit(1'b1, 5, 5, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(word_out == 32'd0, "R10 word after mid-word reset", word_out, 32'd0);
    rst_n = 1'b1;
    begin
      int base;
      base = strobes;
      send_word(32'h600D_CAFE, 0, 40);
      repeat (20) @(negedge clk);
      check(strobes - base == 1, "R6 gap after reset", 32'(strobes - base), 32'd1);
      check(last_word == 32'h600D_CAFE, "R3 word after reset", last_word, 32'h600D_CAFE);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule